// File: doc/BRIEF.md
# ADC Trigger and Ready Controller

This block sits on a byte-wide register bus in a data-acquisition design and runs analog-to-digital conversions. A 3-bit operation-mode register chooses which start source may launch a conversion and how a finished sample is announced. The start source is one of a bus write to a strobe address, a tick from an internal pacer timer, or a rising edge on an external trigger pin. A finished sample is announced either by an interrupt request or by a flag that software polls.

When the chosen source fires and no conversion is running, the block sends a one-cycle start pulse to the converter. It then waits for the converter's completion strobe and latches the 12-bit result. The result is readable as a low byte and a high byte. The high byte also carries an active-low ready flag. Reading the low byte marks the sample as consumed and withdraws any pending interrupt.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset the mode is 0 (disabled), the ready flag reads 1 (no valid data), `irq` is low, no start pulse is issued, and the stored result is zero.
- R2: A write to offset 11 loads bits 2:0 into the mode register, which reads back at offset 11 in bits 2:0 with bits 7:3 zero. Mode codes are: 1 strobe/polling, 2 pacer/interrupt, 3 pacer/polling, 4 external/interrupt, 5 external/polling. Codes 0, 6 and 7 disable every source.
- R3: In mode 1, any write to offset 12 starts a conversion, whatever the data written.
- R4: In modes 2 and 3, a high `pacer_tick` starts a conversion. In modes 4 and 5, each rising edge of `ext_trig_in` starts exactly one conversion after a two-flop synchronizer, and a level held high does not start another. Sources other than the selected one are ignored.
- R5: `conv_start` is a single-cycle pulse issued on the clock edge that samples an accepted request. A request that arrives while a conversion is running is dropped and is not queued.
- R6: A `conv_done` during a running conversion latches `conv_result` and drives the ready flag to 0. A `conv_done` while no conversion runs has no effect.
- R7: Reading offset 4 returns result bits 7:0. Reading offset 5 returns result bits 11:8 in bits 3:0, the ready flag in bit 4, and zero in bits 7:5. All other offsets read zero.
- R8: A read strobe at offset 4 sets the ready flag back to 1. A read at offset 5 leaves it unchanged.
- R9: In modes 2 and 4, `irq` rises when a conversion completes and stays high until offset 4 is read. In modes 1, 3 and 5, `irq` stays low.
- R10: If a completion and a read of offset 4 fall in the same cycle, the completion wins and the ready flag ends at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 4 | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe (side effect only at offset 4) |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| pacer_tick | input | 1 | Pacer timer tick |
| ext_trig_in | input | 1 | Asynchronous external trigger |
| conv_start | output | 1 | Start pulse to the converter |
| conv_done | input | 1 | Converter completion strobe |
| conv_result | input | 12 | Converter result, valid with `conv_done` |
| irq | output | 1 | Interrupt request |

## Verification
The hardest cases are the ones where two events collide in the same cycle. One is a completion arriving in the same cycle as a low-byte read. Another is a request arriving while the converter is still busy. The free-running converter model in the bench cannot place its completion strobe precisely enough for these, so the bench switches it to a manual mode and drives the completion strobe by hand in a chosen cycle. That cycle is lined up with a low-byte read, with repeated pacer ticks, or with a period when no conversion is running. A cycle-by-cycle reference model checks every clock, so each of these collisions is judged at the exact cycle it happens.

// File: rtl/adc_seq_pkg.sv
// Shared types for the ADC trigger/ready controller.
// Assumes a 3-bit mode code; unlisted codes decode as disabled.
package adc_seq_pkg;

    typedef enum logic [1:0] {
        SRC_NONE  = 2'd0,
        SRC_SW    = 2'd1,
        SRC_PACER = 2'd2,
        SRC_EXT   = 2'd3
    } trig_src_e;

    typedef struct packed {
        trig_src_e src;
        logic      irq_en;
    } mode_cfg_t;

    // Turns a raw mode code into a source selection and an interrupt enable.
    function automatic mode_cfg_t decode_mode(input logic [2:0] code);
        mode_cfg_t c;
        c.src    = SRC_NONE;
        c.irq_en = 1'b0;
        case (code)
            3'd1: c.src = SRC_SW;
            3'd2: begin c.src = SRC_PACER; c.irq_en = 1'b1; end
            3'd3: c.src = SRC_PACER;
            3'd4: begin c.src = SRC_EXT;   c.irq_en = 1'b1; end
            3'd5: c.src = SRC_EXT;
            default: ;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/adc_edge_sync.sv
// Synchronizes an asynchronous level and flags its rising edge.
// Assumes STAGES >= 2; the flag is a one-cycle pulse in the clk domain.
module adc_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    logic [STAGES:0] sh_q;

    // Shifts the input through the synchronizer plus one history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[STAGES-1:0], async_in};
    end

    assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/adc_trig_gate.sv
// Picks the selected start source, drops requests while busy, and
// issues a one-cycle start pulse. Busy ends on the converter's done strobe.
module adc_trig_gate
    import adc_seq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  mode_cfg_t cfg,
    input  logic      sw_req,
    input  logic      pacer_req,
    input  logic      ext_req,
    input  logic      conv_done,
    output logic      conv_start,
    output logic      busy
);
    logic sel_req;
    logic fire;
    logic start_q;
    logic busy_q;

    // Routes only the request of the selected source.
    always_comb begin
        case (cfg.src)
            SRC_SW:    sel_req = sw_req;
            SRC_PACER: sel_req = pacer_req;
            SRC_EXT:   sel_req = ext_req;
            default:   sel_req = 1'b0;
        endcase
    end

    assign fire = sel_req & ~busy_q;

    // Registers the start pulse and tracks the running conversion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= 1'b0;
            busy_q  <= 1'b0;
        end else begin
            start_q <= fire;
            busy_q  <= busy_q ? ~conv_done : fire;
        end
    end

    assign conv_start = start_q;
    assign busy       = busy_q;

    p_start_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        start_q |=> !start_q);
    p_start_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        start_q |-> busy_q);
    p_off_no_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.src == SRC_NONE) |=> !start_q);
endmodule

// File: rtl/adc_result_reg.sv
// Holds the latest result, the active-low ready flag and the interrupt.
// Assumes a completion counts only while a conversion is running.
module adc_result_reg #(
    parameter int RES_W  = 12,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              irq_en,
    input  logic              busy,
    input  logic              conv_done,
    input  logic [RES_W-1:0]  conv_result,
    input  logic              rd_lo,
    output logic [DATA_W-1:0] data_lo,
    output logic [DATA_W-1:0] data_hi,
    output logic              irq
);
    localparam int HI_W  = RES_W - DATA_W;
    localparam int PAD_W = DATA_W - HI_W - 1;

    logic [RES_W-1:0] res_q;
    logic             ready_n_q;
    logic             irq_q;
    logic             capture;

    assign capture = busy & conv_done;

    // Latches a result on completion; a low-byte read consumes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q     <= '0;
            ready_n_q <= 1'b1;
            irq_q     <= 1'b0;
        end else if (capture) begin
            res_q     <= conv_result;
            ready_n_q <= 1'b0;
            irq_q     <= irq_en;
        end else if (rd_lo) begin
            ready_n_q <= 1'b1;
            irq_q     <= 1'b0;
        end
    end

    assign data_lo = res_q[DATA_W-1:0];
    assign data_hi = {{PAD_W{1'b0}}, ready_n_q, res_q[RES_W-1:DATA_W]};
    assign irq     = irq_q;

    p_done_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && conv_done) |=> !ready_n_q);
    p_read_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_lo && !(busy && conv_done)) |=> (ready_n_q && !irq_q));
    p_irq_mode_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_q) |-> $past(irq_en));
    p_idle_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !rd_lo) |=> $stable(ready_n_q));
endmodule

// File: rtl/adc_seq_ctrl.sv
// Top of the ADC trigger/ready controller: register decode, mode register,
// read mux, and wiring of synchronizer, trigger gate and result register.
// Assumes a byte bus with combinational read data.
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int ADDR_W     = 4,
    parameter int DATA_W     = 8,
    parameter int RES_W      = 12,
    parameter int SYNC_STAGES = 2,
    parameter int OFS_LO     = 4,
    parameter int OFS_HI     = 5,
    parameter int OFS_MODE   = 11,
    parameter int OFS_STROBE = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              pacer_tick,
    input  logic              ext_trig_in,
    output logic              conv_start,
    input  logic              conv_done,
    input  logic [RES_W-1:0]  conv_result,
    output logic              irq
);
    localparam int MODE_W = 3;

    logic [MODE_W-1:0] mode_q;
    mode_cfg_t         cfg;
    logic              sw_req, rd_lo, ext_rise, busy;
    logic [DATA_W-1:0] data_lo, data_hi;

    assign cfg    = decode_mode(mode_q);
    assign sw_req = bus_wr && (bus_addr == ADDR_W'(OFS_STROBE));
    assign rd_lo  = bus_rd && (bus_addr == ADDR_W'(OFS_LO));

    // Loads the mode code from the low bits of a write at the mode offset.
    always_ff @(posedge clk) begin
        if (!rst_n)                                         mode_q <= '0;
        else if (bus_wr && bus_addr == ADDR_W'(OFS_MODE))   mode_q <= bus_wdata[MODE_W-1:0];
    end

    // Selects the readable register for the current offset.
    always_comb begin
        if (bus_addr == ADDR_W'(OFS_LO))        bus_rdata = data_lo;
        else if (bus_addr == ADDR_W'(OFS_HI))   bus_rdata = data_hi;
        else if (bus_addr == ADDR_W'(OFS_MODE)) bus_rdata = {{(DATA_W-MODE_W){1'b0}}, mode_q};
        else                                    bus_rdata = '0;
    end

    adc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(ext_trig_in), .rise(ext_rise)
    );

    adc_trig_gate u_gate (
        .clk(clk), .rst_n(rst_n), .cfg(cfg), .sw_req(sw_req),
        .pacer_req(pacer_tick), .ext_req(ext_rise), .conv_done(conv_done),
        .conv_start(conv_start), .busy(busy)
    );

    adc_result_reg #(.RES_W(RES_W), .DATA_W(DATA_W)) u_res (
        .clk(clk), .rst_n(rst_n), .irq_en(cfg.irq_en), .busy(busy),
        .conv_done(conv_done), .conv_result(conv_result), .rd_lo(rd_lo),
        .data_lo(data_lo), .data_hi(data_hi), .irq(irq)
    );

    p_mode_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(OFS_MODE)) |=> (mode_q == $past(bus_wdata[MODE_W-1:0])));
endmodule

// File: tb/adc_seq_ctrl_tb.sv
// Self-checking bench: behavioural reference model compared every clock,
// plus directed checks per requirement.
module adc_seq_ctrl_tb_top;
    localparam int CLK_P = 10;
    localparam int LAT   = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        pacer_tick = 1'b0, ext_trig_in = 1'b0;
    logic        conv_start, conv_done, irq;
    logic [11:0] conv_result = '0;
    logic        auto_done = 1'b0, spur_done = 1'b0, manual = 1'b0;

    int errors = 0, checks = 0, n_starts = 0, cnt = 0, res_seq = 0;
    int m_mode, m_busy, m_ready_n, m_irq, m_res, m_start, e1, e2, e3;
    int rise, req, ien, cap;
    bit cmp_on = 0;

    always #(CLK_P/2) clk = ~clk;
    assign conv_done = auto_done | spur_done;

    adc_seq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .pacer_tick(pacer_tick), .ext_trig_in(ext_trig_in),
        .conv_start(conv_start), .conv_done(conv_done),
        .conv_result(conv_result), .irq(irq)
    );

    task automatic check(input string req_s, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req_s, act, exp, $time);
        end
    endtask

    function automatic int model_rd(input int a);
        if (a == 4)  return m_res & 8'hFF;
        if (a == 5)  return ((m_res >> 8) & 4'hF) | (m_ready_n << 4);
        if (a == 11) return m_mode;
        return 0;
    endfunction

    // Reference model: updates from the inputs sampled at each edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_busy = 0; m_ready_n = 1; m_irq = 0; m_res = 0;
            m_start = 0; e1 = 0; e2 = 0; e3 = 0;
        end else begin
            rise = (e2 && !e3) ? 1 : 0;
            e3 = e2; e2 = e1; e1 = int'(ext_trig_in);
            req = ((m_mode == 1 && bus_wr && bus_addr == 12) ||
                   ((m_mode == 2 || m_mode == 3) && pacer_tick) ||
                   ((m_mode == 4 || m_mode == 5) && rise != 0)) ? 1 : 0;
            ien = (m_mode == 2 || m_mode == 4) ? 1 : 0;
            cap = (m_busy != 0 && conv_done) ? 1 : 0;
            if (cap != 0) begin
                m_res = int'(conv_result); m_ready_n = 0; m_irq = ien;
            end else if (bus_rd && bus_addr == 4) begin
                m_ready_n = 1; m_irq = 0;
            end
            m_start = (req != 0 && m_busy == 0) ? 1 : 0;
            m_busy  = (m_busy != 0) ? (conv_done ? 0 : 1) : req;
            if (bus_wr && bus_addr == 11) m_mode = int'(bus_wdata) & 7;
        end
        cmp_on = 1;
    end

    // Per-cycle comparison against the model, away from the edge.
    always @(negedge clk) begin
        #1;
        if (cmp_on && rst_n) begin
            check("cycle model R5 start", int'(conv_start), m_start);
            check("cycle model R9 irq", int'(irq), m_irq);
            check("cycle model R7 rdata", int'(bus_rdata), model_rd(int'(bus_addr)));
        end
    end

    // Converter model: completes LAT cycles after each start unless manual.
    always @(negedge clk) begin
        if (conv_start === 1'b1) begin
            n_starts++;
            cnt = manual ? 0 : LAT;
            auto_done = 1'b0;
            res_seq++;
            conv_result = 12'(12'h0A5 + res_seq * 12'h137);
        end else if (cnt > 0) begin
            cnt--;
            auto_done = (cnt == 0);
        end else auto_done = 1'b0;
    end

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask
    task automatic wr(input int a, input int d);
        @(negedge clk); bus_addr = 4'(a); bus_wdata = 8'(d); bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
    endtask
    task automatic rd(input int a, output int v);
        @(negedge clk); bus_addr = 4'(a); bus_rd = 1'b1; #1 v = int'(bus_rdata);
        @(negedge clk); bus_rd = 1'b0;
    endtask
    task automatic peek(input int a, output int v);
        @(negedge clk); bus_addr = 4'(a); #1 v = int'(bus_rdata);
    endtask
    task automatic tick();
        @(negedge clk); pacer_tick = 1'b1;
        @(negedge clk); pacer_tick = 1'b0;
    endtask

    initial begin
        int v, s0;
        cyc(3); @(negedge clk); rst_n = 1'b1;
        peek(5, v); check("R1 ready flag idle", v, 8'h10);
        peek(4, v); check("R1 result zero", v, 0);
        peek(11, v); check("R1 mode zero", v, 0);
        check("R1 irq low", int'(irq), 0);

        s0 = n_starts; wr(12, 8'h55); tick(); cyc(6);
        check("R2 disabled mode no start", n_starts - s0, 0);

        wr(11, 8'hF9); peek(11, v); check("R2 mode readback low bits", v, 1);
        s0 = n_starts; wr(12, 8'h00); cyc(8);
        check("R3 strobe starts one conversion", n_starts - s0, 1);
        peek(5, v); check("R6 ready low after done", (v >> 4) & 1, 0);
        check("R7 high byte upper bits zero", v & 8'hE0, 0);
        check("R9 no irq in strobe mode", int'(irq), 0);
        rd(5, v); peek(5, v); check("R8 high read keeps ready", (v >> 4) & 1, 0);
        rd(4, v); peek(5, v); check("R8 low read sets ready", (v >> 4) & 1, 1);
        s0 = n_starts; tick(); ext_trig_in = 1'b1; cyc(8); ext_trig_in = 1'b0; cyc(4);
        check("R4 unselected sources ignored", n_starts - s0, 0);

        wr(11, 2); s0 = n_starts; tick(); cyc(8);
        check("R4 pacer starts", n_starts - s0, 1);
        check("R9 irq raised in interrupt mode", int'(irq), 1);
        rd(5, v); check("R9 irq held after high read", int'(irq), 1);
        rd(4, v); cyc(1); check("R9 irq cleared by low read", int'(irq), 0);

        wr(11, 3); tick(); cyc(8);
        check("R9 no irq pacer polling", int'(irq), 0);
        rd(4, v);

        wr(11, 4); s0 = n_starts; cyc(1); ext_trig_in = 1'b1; cyc(12);
        check("R4 one start per ext edge", n_starts - s0, 1);
        check("R9 irq ext interrupt", int'(irq), 1);
        ext_trig_in = 1'b0; cyc(3); rd(4, v);
        wr(11, 5); s0 = n_starts; ext_trig_in = 1'b1; cyc(8); ext_trig_in = 1'b0;
        cyc(3); ext_trig_in = 1'b1; cyc(8); ext_trig_in = 1'b0; cyc(3);
        check("R4 two ext edges two starts", n_starts - s0, 2);
        rd(4, v);

        manual = 1'b1; wr(11, 3); s0 = n_starts;
        tick(); tick(); tick(); cyc(2);
        check("R5 busy drops requests", n_starts - s0, 1);
        @(negedge clk); spur_done = 1'b1; bus_addr = 4; bus_rd = 1'b1;
        @(negedge clk); spur_done = 1'b0; bus_rd = 1'b0;
        peek(5, v); check("R10 done beats low read", (v >> 4) & 1, 0);
        rd(4, v);
        peek(4, s0);
        @(negedge clk); spur_done = 1'b1; @(negedge clk); spur_done = 1'b0;
        peek(5, v); check("R6 idle done ignored ready", (v >> 4) & 1, 1);
        peek(4, v); check("R6 idle done keeps result", v, s0);
        wr(11, 6); s0 = n_starts; tick(); wr(12, 1); cyc(4);
        check("R2 code 6 disabled", n_starts - s0, 0);
        peek(7, v); check("R7 unused offset reads zero", v, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_P * 100000);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule